// File: doc/BRIEF.md
# Interleaved YCbCr Input Demultiplexer

This block takes progressive-scan 4:2:2 video whose luma and two colour-difference components share one byte-wide bus. It finds the embedded timing codes in the stream and splits the active picture into a luma lane and a chroma lane. Each lane has its own valid strobe. The chroma lane also carries a tag that says whether the byte is blue-difference or red-difference. It emits one-cycle pulses at start and end of active video, and it holds the field, vertical-blank and horizontal bits of the most recent timing code.

There are two capture modes. In single-edge mode the bus carries one byte per rising clock edge. In dual-edge mode the bus carries a byte on each edge of a clock that runs at half the byte rate. A falling-edge register and a rising-edge register capture the bytes, and they are merged so that each rising-edge cycle delivers one chroma byte and one luma byte. A polarity input tells the block which edge carries the chroma byte, so the merge always pairs a chroma byte with the luma byte that follows it. In dual-edge mode a timing code must start on a chroma slot.

Top module: `yc_demux`

## Requirements
- R1: While reset is asserted and after it is released with no input, `lumaValid`, `chromaValid`, `savPulse`, `eavPulse`, `fieldBit`, `vblankBit` and `hBit` are 0.
- R2: With `dualEdge`=0, one byte is taken per rising edge. After a start code, active bytes are classed in a repeating cycle of Cb, Y, Cr, Y. A Y byte appears on `lumaData` and a Cb or Cr byte appears on `chromaData`, with `chromaIsCr` 0 for Cb and 1 for Cr. Each sample is presented in the cycle after the edge that sampled it, and luma and chroma are never valid in the same cycle.
- R3: With `dualEdge`=1 and `lumaFirst`=0, the rising-edge byte is the chroma byte and the following falling-edge byte is the luma byte. Both are presented in the same cycle.
- R4: With `dualEdge`=1 and `lumaFirst`=1, the falling-edge byte is the chroma byte and it is paired with the luma byte of the next rising edge. Both are presented in the same cycle.
- R5: A timing code is the byte run 0xFF, 0x00, 0x00, XY, where bit 7 of XY is 1. Bit 6 of XY is the field bit, bit 5 is vertical blank and bit 4 is H. H=0 gives a one-cycle `savPulse` and H=1 gives a one-cycle `eavPulse`. The pulse appears in the same cycle that the first sample from the byte at the same position would have appeared.
- R6: `fieldBit`, `vblankBit` and `hBit` change only in the cycle of a pulse. They hold the bits of the last accepted code.
- R7: No sample is emitted between an end code and the next start code. Code bytes are never emitted as samples.
- R8: A broken code produces no pulse and leaves the flags unchanged. This covers 0xFF 0x00 followed by a byte other than 0x00, and a full run whose fourth byte has bit 7 = 0.
- R9: The first chroma byte after every start code is tagged Cb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock (byte clock or half-rate clock) |
| rstN | input | 1 | Asynchronous active-low reset |
| dualEdge | input | 1 | 1: bytes on both edges; 0: bytes on rising edges only |
| lumaFirst | input | 1 | Dual-edge polarity: 0 chroma on rising edge, 1 luma on rising edge |
| dataIn | input | 8 | Interleaved YCbCr byte bus |
| lumaData | output | 8 | Luma sample |
| lumaValid | output | 1 | Luma sample valid |
| chromaData | output | 8 | Chroma sample |
| chromaValid | output | 1 | Chroma sample valid |
| chromaIsCr | output | 1 | 0 Cb, 1 Cr |
| savPulse | output | 1 | Start-of-active-video pulse |
| eavPulse | output | 1 | End-of-active-video pulse |
| fieldBit | output | 1 | Field bit of last code |
| vblankBit | output | 1 | Vertical-blank bit of last code |
| hBit | output | 1 | H bit of last code |

## Verification
The bench sweeps both capture modes and both dual-edge polarities across the field and blank combinations. A wrong polarity merge would swap or shift the lanes, so the bench compares every luma and chroma byte and every Cb/Cr tag against arithmetic values. Aborted codes and codes whose fourth byte has bit 7 clear are placed in blanking, where a loose detector would fire a stray pulse, corrupt the flags or reopen the active window. The bench also measures the cycle offset of the start pulse in each mode, which catches a misplaced merge register, and it checks that blanking bytes after an end code never leak out as samples.

// File: rtl/yc_pkg.sv
package yc_pkg;
  // Strobes from the parser to the datapath, valid for one rising-edge cycle.
  typedef struct packed {
    logic       emitC;   // chroma lane byte is a sample
    logic       emitY;   // luma byte is a sample
    logic       isCr;    // chroma byte is red-difference
    logic       sav;     // start code accepted
    logic       eav;     // end code accepted
    logic [2:0] fvh;     // field, vblank, H of the accepted code
  } ycStrobe_t;
endpackage

// File: rtl/yc_parse.sv
module yc_parse
  import yc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          dualEdge,
  input  logic [DW-1:0] lane0,
  input  logic [DW-1:0] lane1,
  output ycStrobe_t     st
);
  localparam int TOP = DW - 1;

  logic       active, activeNx;
  logic [1:0] phase, phaseNx;
  logic [1:0] match, matchNx;
  logic       evt, dataSlot;
  logic [DW-1:0] xyByte;

  assign xyByte = dualEdge ? lane1 : lane0;

  always_comb begin
    st       = '0;
    activeNx = active;
    phaseNx  = phase;
    matchNx  = '0;
    evt      = 1'b0;
    dataSlot = 1'b0;
    if (!dualEdge) begin
      if (match == 2'd3 && lane0[TOP])                       evt = 1'b1;
      else if (lane0 == '1)                                  matchNx = 2'd1;
      else if (lane0 == '0 && match != 2'd0 && match != 2'd3) matchNx = match + 2'd1;
      else                                                   dataSlot = 1'b1;
    end else begin
      if (match == 2'd1 && lane0 == '0 && lane1[TOP])        evt = 1'b1;
      else if (lane0 == '1 && lane1 == '0)                   matchNx = 2'd1;
      else                                                   dataSlot = 1'b1;
    end
    if (evt) begin
      st.fvh = xyByte[TOP-1 -: 3];
      st.sav = !xyByte[TOP-3];
      st.eav = xyByte[TOP-3];
      if (!xyByte[TOP-3]) begin
        activeNx = 1'b1;
        phaseNx  = 2'd0;
      end else begin
        activeNx = 1'b0;
      end
    end
    if (dataSlot && active) begin
      st.isCr = phase[1];
      if (dualEdge) begin
        st.emitC = 1'b1;
        st.emitY = 1'b1;
        phaseNx  = phase + 2'd2;
      end else begin
        st.emitC = !phase[0];
        st.emitY = phase[0];
        phaseNx  = phase + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      phase  <= '0;
      match  <= '0;
    end else begin
      active <= activeNx;
      phase  <= phaseNx;
      match  <= matchNx;
    end
  end

  // R7: nothing is emitted outside the active window
  assert_no_idle_emit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (st.emitC || st.emitY) |-> active);
endmodule

// File: rtl/yc_datapath.sv
module yc_datapath
  import yc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          dualEdge,
  input  logic          lumaFirst,
  input  logic [DW-1:0] dataIn,
  output logic [DW-1:0] lane0,
  output logic [DW-1:0] lane1,
  input  ycStrobe_t     st,
  output logic [DW-1:0] lumaData,
  output logic          lumaValid,
  output logic [DW-1:0] chromaData,
  output logic          chromaValid,
  output logic          chromaIsCr,
  output logic          savPulse,
  output logic          eavPulse,
  output logic [2:0]    flags
);
  logic [DW-1:0] riseReg, fallReg, fallHold;

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) fallReg <= '0;
    else       fallReg <= dataIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseReg  <= '0;
      fallHold <= '0;
    end else begin
      riseReg  <= dataIn;
      fallHold <= fallReg;
    end
  end

  // Lane 0 always holds the chroma-slot byte, lane 1 the luma-slot byte.
  assign lane0 = (dualEdge && lumaFirst) ? fallHold : riseReg;
  assign lane1 = lumaFirst ? riseReg : fallReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lumaData    <= '0;
      lumaValid   <= 1'b0;
      chromaData  <= '0;
      chromaValid <= 1'b0;
      chromaIsCr  <= 1'b0;
      savPulse    <= 1'b0;
      eavPulse    <= 1'b0;
      flags       <= '0;
    end else begin
      lumaValid   <= st.emitY;
      chromaValid <= st.emitC;
      savPulse    <= st.sav;
      eavPulse    <= st.eav;
      if (st.emitY) lumaData <= dualEdge ? lane1 : lane0;
      if (st.emitC) begin
        chromaData <= lane0;
        chromaIsCr <= st.isCr;
      end
      if (st.sav || st.eav) flags <= st.fvh;
    end
  end

  // Checker state: a Cb byte is due after a start pulse.
  logic cbDue;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cbDue <= 1'b0;
    else if (savPulse)    cbDue <= 1'b1;
    else if (chromaValid) cbDue <= 1'b0;
  end

  assert_single_lane_R2: assert property (@(posedge clk) disable iff (!rstN)
    (lumaValid && !dualEdge) |-> !chromaValid);
  assert_dual_pair_R3: assert property (@(posedge clk) disable iff (!rstN)
    (dualEdge && (lumaValid || chromaValid)) |-> (lumaValid && chromaValid));
  assert_pulse_once_R5: assert property (@(posedge clk) disable iff (!rstN)
    (savPulse || eavPulse) |=> !(savPulse || eavPulse));
  assert_quiet_after_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    eavPulse |=> !(lumaValid || chromaValid));
  assert_cb_first_R9: assert property (@(posedge clk) disable iff (!rstN)
    (chromaValid && cbDue) |-> !chromaIsCr);
  assert_flags_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(savPulse || eavPulse) |=> (savPulse || eavPulse || $stable(flags)));
endmodule

// File: rtl/yc_demux.sv
module yc_demux
  import yc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          dualEdge,
  input  logic          lumaFirst,
  input  logic [DW-1:0] dataIn,
  output logic [DW-1:0] lumaData,
  output logic          lumaValid,
  output logic [DW-1:0] chromaData,
  output logic          chromaValid,
  output logic          chromaIsCr,
  output logic          savPulse,
  output logic          eavPulse,
  output logic          fieldBit,
  output logic          vblankBit,
  output logic          hBit
);
  ycStrobe_t     st;
  logic [DW-1:0] lane0, lane1;
  logic [2:0]    flags;

  yc_parse #(.DW(DW)) uParse (
    .clk(clk), .rstN(rstN), .dualEdge(dualEdge),
    .lane0(lane0), .lane1(lane1), .st(st)
  );

  yc_datapath #(.DW(DW)) uPath (
    .clk(clk), .rstN(rstN), .dualEdge(dualEdge), .lumaFirst(lumaFirst),
    .dataIn(dataIn), .lane0(lane0), .lane1(lane1), .st(st),
    .lumaData(lumaData), .lumaValid(lumaValid),
    .chromaData(chromaData), .chromaValid(chromaValid), .chromaIsCr(chromaIsCr),
    .savPulse(savPulse), .eavPulse(eavPulse), .flags(flags)
  );

  assign fieldBit  = flags[2];
  assign vblankBit = flags[1];
  assign hBit      = flags[0];
endmodule

// File: tb/sim_yc_demux.sv
`timescale 1ns/1ps
module sim_yc_demux;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dualEdge = 1'b0, lumaFirst = 1'b0;
  logic [7:0] dataIn = 8'h80;
  logic [7:0] lumaData, chromaData;
  logic lumaValid, chromaValid, chromaIsCr, savPulse, eavPulse;
  logic fieldBit, vblankBit, hBit;

  always #2 clk = ~clk;

  yc_demux u0 (
    .clk(clk), .rstN(rstN), .dualEdge(dualEdge), .lumaFirst(lumaFirst),
    .dataIn(dataIn), .lumaData(lumaData), .lumaValid(lumaValid),
    .chromaData(chromaData), .chromaValid(chromaValid), .chromaIsCr(chromaIsCr),
    .savPulse(savPulse), .eavPulse(eavPulse),
    .fieldBit(fieldBit), .vblankBit(vblankBit), .hBit(hBit)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Stream and expectations
  logic [7:0] stream [0:127];
  int sLen, savIdx;
  logic [7:0] expY [0:31];
  logic [7:0] expC [0:31];
  bit         expT [0:31];

  // Monitor
  logic [7:0] gotY [0:63];
  logic [7:0] gotC [0:63];
  bit         gotT [0:63];
  int nY, nC, savCnt, eavCnt, badPair, both, flagDrift, savCyc, xyCyc;
  logic [2:0] savFlags, eavFlags, lastFlags;

  always @(negedge clk) begin
    if (rstN) begin
      if (lumaValid && nY < 64) begin gotY[nY] = lumaData; nY++; end
      if (chromaValid && nC < 64) begin gotC[nC] = chromaData; gotT[nC] = chromaIsCr; nC++; end
      if (lumaValid && chromaValid) both++;
      if (lumaValid != chromaValid && dualEdge) badPair++;
      if (savPulse) begin savCnt++; savFlags = {fieldBit, vblankBit, hBit}; savCyc = cyc; end
      if (eavPulse) begin eavCnt++; eavFlags = {fieldBit, vblankBit, hBit}; end
      if (!savPulse && !eavPulse && {fieldBit, vblankBit, hBit} != lastFlags) flagDrift++;
      lastFlags = {fieldBit, vblankBit, hBit};
    end
  end

  task automatic put(input logic [7:0] b);
    stream[sLen] = b;
    sLen++;
  endtask

  task automatic build(input bit f, input bit v, input int np);
    sLen = 0;
    put(8'h80); put(8'h10); put(8'h80); put(8'h10);
    put(8'hFF); put(8'h00); put(8'h80); put(8'h10);            // aborted code (R8)
    put(8'hFF); put(8'h00); put(8'h00); put({2'b01, v, 5'b0}); // bit 7 clear (R8)
    savIdx = sLen + 3;
    put(8'hFF); put(8'h00); put(8'h00); put({1'b1, f, v, 1'b0, 4'h0});
    for (int j = 0; j < np; j++) begin
      expC[2*j]   = 8'h40 + 8'(j * 5); expT[2*j]   = 1'b0;
      expC[2*j+1] = 8'h90 + 8'(j * 3); expT[2*j+1] = 1'b1;
      expY[2*j]   = 8'h20 + 8'(4 * j * 9);
      expY[2*j+1] = 8'h20 + 8'((4 * j + 2) * 9);
    end
    for (int j = 0; j < np; j++) begin
      put(expC[2*j]); put(expY[2*j]); put(expC[2*j+1]); put(expY[2*j+1]);
    end
    put(8'hFF); put(8'h00); put(8'h00); put({1'b1, f, v, 1'b1, 4'h0});
    put(8'h80); put(8'h10); put(8'h80); put(8'h10);              // must stay silent (R7)
  endtask

  task automatic run(input bit de, input bit pol, input bit f, input bit v,
                     input int np, input string req, input int lat);
    @(posedge clk); #1;
    dualEdge = de; lumaFirst = pol; dataIn = 8'h80;
    repeat (3) @(posedge clk);
    #1;
    nY = 0; nC = 0; savCnt = 0; eavCnt = 0; badPair = 0; both = 0; flagDrift = 0;
    savCyc = -1; xyCyc = 0;
    build(f, v, np);
    if (de && !pol) begin @(negedge clk); #1; end
    else if (de && pol) begin @(posedge clk); #1; end
    else begin @(posedge clk); #1; end
    for (int i = 0; i < sLen; i++) begin
      dataIn = stream[i];
      if (i == savIdx) xyCyc = cyc;
      if (de) @(clk); else @(posedge clk);
      #1;
    end
    dataIn = 8'h80;
    repeat (6) @(posedge clk);
    #1;
    chk(nY == 2 * np, {req, " luma count"}, nY, 2 * np);
    chk(nC == 2 * np, {req, " chroma count R7"}, nC, 2 * np);
    for (int k = 0; k < 2 * np && k < nY; k++)
      chk(gotY[k] == expY[k], {req, " luma byte"}, gotY[k], expY[k]);
    for (int k = 0; k < 2 * np && k < nC; k++) begin
      chk(gotC[k] == expC[k], {req, " chroma byte"}, gotC[k], expC[k]);
      chk(gotT[k] == expT[k], {req, " chroma tag R9"}, gotT[k], expT[k]);
    end
    chk(savCnt == 1, "R5 R8 start pulse count", savCnt, 1);
    chk(eavCnt == 1, "R5 end pulse count", eavCnt, 1);
    chk(savFlags == {f, v, 1'b0}, "R5 flags at start", savFlags, {f, v, 1'b0});
    chk(eavFlags == {f, v, 1'b1}, "R6 flags at end", eavFlags, {f, v, 1'b1});
    chk(flagDrift == 0, "R6 R8 flags change without pulse", flagDrift, 0);
    chk(savCyc - xyCyc == lat, {req, " R5 start pulse latency"}, savCyc - xyCyc, lat);
    if (de) chk(badPair == 0, "R3 R4 lanes paired", badPair, 0);
    else    chk(both == 0, "R2 one lane per cycle", both, 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!lumaValid && !chromaValid, "R1 valids in reset", {lumaValid, chromaValid}, 0);
    chk(!savPulse && !eavPulse, "R1 pulses in reset", {savPulse, eavPulse}, 0);
    rstN = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk({fieldBit, vblankBit, hBit} == 3'b000, "R1 flags after reset",
        {fieldBit, vblankBit, hBit}, 0);
    chk(!lumaValid && !chromaValid, "R1 idle after reset", {lumaValid, chromaValid}, 0);
    lastFlags = 3'b000;
    run(1'b0, 1'b0, 1'b0, 1'b0, 4, "R2 single", 2);
    run(1'b0, 1'b0, 1'b1, 1'b1, 3, "R2 single fv", 2);
    run(1'b1, 1'b0, 1'b1, 1'b0, 4, "R3 dual chroma-rise", 1);
    run(1'b1, 1'b1, 1'b0, 1'b1, 4, "R4 dual luma-rise", 2);
    run(1'b1, 1'b0, 1'b0, 1'b0, 2, "R3 dual short", 1);
    run(1'b1, 1'b1, 1'b1, 1'b1, 2, "R4 dual short", 2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule